// File: doc/BRIEF.md
# Interrupt Source Router with Round-Robin Distribution

This block holds the routing state of a set of interrupt sources and turns every change to one source into activate or deactivate events for a group of up to eight CPU gates. Each source has four stored items: a configuration word, a CPU destination mask, a pending flag and a round-robin pointer. The configuration word carries the priority, sense, polarity, delivery mode, mask and a read-only activity bit. One update port either writes a source's configuration, its destination mask or its pending flag, or re-evaluates the source without changing anything. In the same clock edge the block works out the source's new activity, stores it, and chooses which CPUs are told.

A source is treated as active when it is pending and not masked. A source listed in a parameter as exempt from masking ignores its mask. Nothing is sent when a source was inactive and stays inactive. A source that was active is always re-evaluated, so that a later change can withdraw it.

Routing has three cases. A destination mask that holds only the last CPU served goes straight to that CPU. Directed mode broadcasts to every CPU in the mask. Distributed mode picks exactly one CPU: it scans round-robin starting just after the last CPU served, and the CPU it picks becomes the new last CPU served.

Source classes are fixed by index:
- Sources with the lowest indices are external.
- The next ones are internal.
- The remaining ones are timer or doorbell sources.

The class controls how configuration writes are filtered and whether the source is level or edge sensitive. The per-CPU priority gates receive the one-cycle event vector and its shared payload.

Top module: `irq_route`

## Requirements
- R1: A source's new activity is its pending flag AND NOT its mask bit (configuration bit 7). Sources whose bit is set in MASK_EXEMPT ignore the mask bit.
- R2: An update that leaves a source inactive and finds it was inactive produces no event (all event bits zero). A source that was active always produces an event on update, whether it stays active or drops.
- R3: Configuration bit 8 holds the source's current activity and is rewritten on every update that produces an event. A configuration write cannot change it: the value written to bit 8 is discarded.
- R4: A source whose destination mask is zero produces no event on any CPU. Its activity bit is still updated.
- R5: If the destination mask equals exactly the one-hot bit of the source's last CPU served, only that CPU gets the event, in either mode.
- R6: With the delivery mode bit (configuration bit 6) clear, every CPU set in the destination mask gets the event, and no other CPU does.
- R7: With the mode bit set and the mask not covered by R5, exactly one CPU gets the event: the first CPU set in the mask, scanning upward from last+1 and wrapping at NUM_CPU. It becomes the source's new last CPU served. Last CPU served resets to 0.
- R8: Configuration writes keep the priority (bits 3:0), sense (bit 4), polarity (bit 5), mode and mask. Internal sources have sense forced to 0 and are level sensitive. Timer and doorbell sources have sense and polarity forced to 0 and are edge sensitive. External sources take their level flag from the sense bit.
- R9: Events appear on ev_hit in the cycle after the accepted update and last one cycle. They carry the source index, its priority, the new activity and the previous activity.
- R10: After reset every source reads back configuration 0x080 (masked, inactive), an empty destination mask and no pending flag. Its level flag follows its class, and no event is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Apply one update this cycle |
| upd_kind | input | 2 | 0 configuration write, 1 destination write, 2 pending write, 3 re-evaluate only |
| upd_idx | input | SIW | Source index of the update |
| upd_data | input | 9 | Configuration word, destination mask (low NUM_CPU bits) or pending flag (bit 0) |
| rd_idx | input | SIW | Source selected for readback |
| rd_cfg | output | 9 | Stored configuration word of rd_idx, activity in bit 8 |
| rd_level | output | 1 | 1 when rd_idx is level sensitive |
| ev_hit | output | NUM_CPU | One-cycle per-CPU event strobes |
| ev_src | output | SIW | Source index carried by the event |
| ev_prio | output | 4 | Source priority carried by the event |
| ev_active | output | 1 | New activity (1 activate, 0 deactivate) |
| ev_was_active | output | 1 | Activity before the update |

## Verification
The hardest situation to reach is distributed delivery that depends on a pointer history the ports never show. The target CPU depends on every earlier activation and withdrawal of the same source, and a withdrawal itself moves the pointer to the next CPU in the mask. The bench sweeps every destination mask, under both modes and both mask settings, on every source of each class. It runs activate, mask, unmask and release sequences without resetting the pointer, so the pointer visits every position. A model in the bench carries each source's pointer forward arithmetically and predicts the single target, including the case where only the last-served CPU remains in the mask.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int PRIO_W   = 4;
  localparam int CFG_W    = 9;
  localparam int F_SENSE  = 4;
  localparam int F_POLAR  = 5;
  localparam int F_SPREAD = 6;
  localparam int F_MASK   = 7;
  localparam int F_ACT    = 8;
  localparam logic [CFG_W-1:0] CFG_RESET = 9'h080;

  typedef enum logic [1:0] {
    UPD_CFG  = 2'd0,
    UPD_DEST = 2'd1,
    UPD_PEND = 2'd2,
    UPD_POKE = 2'd3
  } upd_kind_e;

  typedef enum logic [1:0] {
    SRC_EXT      = 2'd0,
    SRC_INTERNAL = 2'd1,
    SRC_SPECIAL  = 2'd2
  } src_class_e;
endpackage

// File: rtl/irq_cfg_filter.sv
module irq_cfg_filter
  import irq_route_pkg::*;
(
  input  src_class_e       cls,
  input  logic [CFG_W-1:0] wdata,
  input  logic             old_act,
  output logic [CFG_W-1:0] word,
  output logic             level
);
  always_comb begin
    word         = wdata;
    word[F_ACT]  = old_act;
    level        = wdata[F_SENSE];
    case (cls)
      SRC_INTERNAL: begin
        word[F_SENSE] = 1'b0;
        level         = 1'b1;
      end
      SRC_SPECIAL: begin
        word[F_SENSE] = 1'b0;
        word[F_POLAR] = 1'b0;
        level         = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] pick
);
  always_comb begin
    int j;
    found = 1'b0;
    pick  = last;
    for (int k = 1; k < N; k++) begin
      j = int'(last) + k;
      if (j >= N) j = j - N;
      if (!found && mask[j]) begin
        found = 1'b1;
        pick  = IW'(j);
      end
    end
  end
endmodule

// File: rtl/irq_route_decide.sv
module irq_route_decide #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  dest,
  input  logic [IW-1:0] last,
  input  logic          spread,
  output logic [N-1:0]  hit,
  output logic          take_last,
  output logic [IW-1:0] new_last
);
  logic          found;
  logic [IW-1:0] pick;
  logic          only_last;

  irq_rr_pick #(.N(N), .IW(IW)) u_pick (
    .mask  (dest),
    .last  (last),
    .found (found),
    .pick  (pick)
  );

  assign only_last = (dest == (N'(1) << last));

  always_comb begin
    hit       = '0;
    take_last = 1'b0;
    new_last  = last;
    if (dest == '0) begin
      hit = '0;
    end else if (only_last || !spread) begin
      hit = dest;
    end else if (found) begin
      hit[pick] = 1'b1;
      take_last = 1'b1;
      new_last  = pick;
    end
  end
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_route_pkg::*;
#(
  parameter int          NUM_SRC      = 8,
  parameter int          NUM_CPU      = 4,
  parameter int          NUM_EXT      = 4,
  parameter int          NUM_INTERNAL = 2,
  parameter int unsigned MASK_EXEMPT  = 1,
  localparam int SIW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CIW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  logic [1:0]        upd_kind,
  input  logic [SIW-1:0]    upd_idx,
  input  logic [CFG_W-1:0]  upd_data,
  input  logic [SIW-1:0]    rd_idx,
  output logic [CFG_W-1:0]  rd_cfg,
  output logic              rd_level,
  output logic [NUM_CPU-1:0] ev_hit,
  output logic [SIW-1:0]    ev_src,
  output logic [PRIO_W-1:0] ev_prio,
  output logic              ev_active,
  output logic              ev_was_active
);
  localparam logic [NUM_SRC-1:0] EXEMPT = MASK_EXEMPT[NUM_SRC-1:0];

  function automatic src_class_e class_of(input logic [SIW-1:0] i);
    if (int'(i) < NUM_EXT) return SRC_EXT;
    if (int'(i) < NUM_EXT + NUM_INTERNAL) return SRC_INTERNAL;
    return SRC_SPECIAL;
  endfunction

  logic [CFG_W-1:0]   cfg_q  [NUM_SRC];
  logic [NUM_CPU-1:0] dst_q  [NUM_SRC];
  logic [CIW-1:0]     last_q [NUM_SRC];
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] lvl_q;

  logic [CFG_W-1:0]   cur_cfg, flt_cfg, nx_cfg, store_cfg;
  logic               flt_lvl;
  logic [NUM_CPU-1:0] nx_dst, hit;
  logic               nx_pend, nx_spread, act_new, act_old, touch;
  logic               take_last;
  logic [CIW-1:0]     new_last;

  assign cur_cfg = cfg_q[upd_idx];
  assign act_old = cur_cfg[F_ACT];

  irq_cfg_filter u_filter (
    .cls     (class_of(upd_idx)),
    .wdata   (upd_data),
    .old_act (act_old),
    .word    (flt_cfg),
    .level   (flt_lvl)
  );

  always_comb begin
    nx_cfg  = (upd_kind == UPD_CFG)  ? flt_cfg : cur_cfg;
    nx_dst  = (upd_kind == UPD_DEST) ? upd_data[NUM_CPU-1:0] : dst_q[upd_idx];
    nx_pend = (upd_kind == UPD_PEND) ? upd_data[0] : pend_q[upd_idx];
    act_new = nx_pend && (!nx_cfg[F_MASK] || EXEMPT[upd_idx]);
    touch   = act_new || act_old;
    store_cfg        = nx_cfg;
    store_cfg[F_ACT] = act_new;
  end

  assign nx_spread = nx_cfg[F_SPREAD];

  irq_route_decide #(.N(NUM_CPU), .IW(CIW)) u_route (
    .dest      (nx_dst),
    .last      (last_q[upd_idx]),
    .spread    (nx_spread),
    .hit       (hit),
    .take_last (take_last),
    .new_last  (new_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        cfg_q[i]  <= CFG_RESET;
        dst_q[i]  <= '0;
        last_q[i] <= '0;
        pend_q[i] <= 1'b0;
        lvl_q[i]  <= (class_of(SIW'(i)) == SRC_INTERNAL);
      end
      ev_hit        <= '0;
      ev_src        <= '0;
      ev_prio       <= '0;
      ev_active     <= 1'b0;
      ev_was_active <= 1'b0;
    end else begin
      ev_hit <= '0;
      if (upd_valid) begin
        cfg_q[upd_idx]  <= store_cfg;
        dst_q[upd_idx]  <= nx_dst;
        pend_q[upd_idx] <= nx_pend;
        if (upd_kind == UPD_CFG) lvl_q[upd_idx] <= flt_lvl;
        if (touch) begin
          ev_hit <= hit;
          if (take_last) last_q[upd_idx] <= new_last;
        end
        ev_src        <= upd_idx;
        ev_prio       <= nx_cfg[PRIO_W-1:0];
        ev_active     <= act_new;
        ev_was_active <= act_old;
      end
    end
  end

  assign rd_cfg   = cfg_q[rd_idx];
  assign rd_level = lvl_q[rd_idx];
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_CPU = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               upd_valid,
  input logic [NUM_CPU-1:0] nx_dst,
  input logic               nx_spread,
  input logic               act_new,
  input logic               act_old,
  input logic [NUM_CPU-1:0] ev_hit,
  input logic               ev_active,
  input logic               ev_was_active
);
  AST_EVT_NEEDS_UPD: assert property (@(posedge clk) disable iff (rst)
    (ev_hit != '0) |-> $past(upd_valid)); // R9
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !act_new && !act_old) |=> (ev_hit == '0)); // R2
  AST_NO_DEST: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && nx_dst == '0) |=> (ev_hit == '0)); // R4
  AST_SPREAD_ONE: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && nx_spread) |=> $onehot0(ev_hit)); // R7
  AST_HIT_IN_DEST: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> ((ev_hit & ~$past(nx_dst)) == '0)); // R6
  AST_FLAG_SANE: assert property (@(posedge clk) disable iff (rst)
    (ev_hit != '0) |-> (ev_active || ev_was_active)); // R2
endmodule

bind irq_route irq_route_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .upd_valid     (upd_valid),
  .nx_dst        (nx_dst),
  .nx_spread     (nx_spread),
  .act_new       (act_new),
  .act_old       (act_old),
  .ev_hit        (ev_hit),
  .ev_active     (ev_active),
  .ev_was_active (ev_was_active)
);

// File: tb/irq_route_test.sv
`timescale 1ns/1ps
module irq_route_test;
  localparam int NS = 8;
  localparam int NC = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       upd_valid = 1'b0;
  logic [1:0] upd_kind = '0;
  logic [2:0] upd_idx = '0;
  logic [8:0] upd_data = '0;
  logic [2:0] rd_idx = '0;
  logic [8:0] rd_cfg;
  logic       rd_level;
  logic [3:0] ev_hit;
  logic [2:0] ev_src;
  logic [3:0] ev_prio;
  logic       ev_active, ev_was_active;

  irq_route #(.NUM_SRC(NS), .NUM_CPU(NC), .NUM_EXT(4), .NUM_INTERNAL(2),
              .MASK_EXEMPT(1)) uut (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_kind(upd_kind),
    .upd_idx(upd_idx), .upd_data(upd_data), .rd_idx(rd_idx),
    .rd_cfg(rd_cfg), .rd_level(rd_level), .ev_hit(ev_hit), .ev_src(ev_src),
    .ev_prio(ev_prio), .ev_active(ev_active), .ev_was_active(ev_was_active));

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [8:0] m_cfg [NS];
  logic [3:0] m_dst [NS];
  int         m_last[NS];
  bit         m_pend[NS];
  bit         m_lvl [NS];

  function automatic int cls_of(int i);
    return (i < 4) ? 0 : (i < 6) ? 1 : 2;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(int kind, int idx, logic [8:0] data);
    logic [8:0] w;
    bit act, was;
    logic [3:0] exp_hit;
    string tag;
    if (kind == 0) begin
      w = data;
      w[8] = m_cfg[idx][8];
      m_lvl[idx] = w[4];
      if (cls_of(idx) == 1) begin w[4] = 1'b0; m_lvl[idx] = 1'b1; end
      if (cls_of(idx) == 2) begin w[4] = 1'b0; w[5] = 1'b0; m_lvl[idx] = 1'b0; end
      m_cfg[idx] = w;
    end else if (kind == 1) m_dst[idx] = data[3:0];
    else if (kind == 2) m_pend[idx] = data[0];
    act = m_pend[idx] && (!m_cfg[idx][7] || idx == 0);
    was = m_cfg[idx][8];
    exp_hit = '0;
    tag = "R2";
    if (act || was) begin
      m_cfg[idx][8] = act;
      if (m_dst[idx] == 0) tag = "R4";
      else if (m_dst[idx] == 4'(1 << m_last[idx])) begin tag = "R5"; exp_hit = m_dst[idx]; end
      else if (!m_cfg[idx][6]) begin tag = "R6"; exp_hit = m_dst[idx]; end
      else begin
        tag = "R7";
        for (int k = 1; k < NC; k++) begin
          int j;
          j = (m_last[idx] + k) % NC;
          if (exp_hit == 0 && m_dst[idx][j]) begin
            exp_hit[j] = 1'b1;
            m_last[idx] = j;
          end
        end
      end
    end
    @(negedge clk);
    upd_valid = 1'b1; upd_kind = 2'(kind); upd_idx = 3'(idx);
    upd_data = data; rd_idx = 3'(idx);
    @(negedge clk);
    upd_valid = 1'b0;
    chk(ev_hit == exp_hit, tag, "event cpus", int'(ev_hit), int'(exp_hit));
    if (exp_hit != 0) begin
      chk(ev_src == 3'(idx), "R9", "event source", int'(ev_src), idx);
      chk(ev_prio == m_cfg[idx][3:0], "R9", "event priority", int'(ev_prio), int'(m_cfg[idx][3:0]));
      chk(ev_active == act && ev_was_active == was, "R9", "event flags",
          int'({ev_active, ev_was_active}), int'({act, was}));
    end
    chk(rd_cfg == m_cfg[idx], "R1/R3/R8", "config readback", int'(rd_cfg), int'(m_cfg[idx]));
    chk(rd_level == m_lvl[idx], "R8", "level flag", int'(rd_level), int'(m_lvl[idx]));
    @(negedge clk);
    chk(ev_hit == 0, "R9", "pulse width", int'(ev_hit), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin
      m_cfg[i] = 9'h080; m_dst[i] = '0; m_last[i] = 0; m_pend[i] = 1'b0;
      m_lvl[i] = (cls_of(i) == 1);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NS; i++) begin
      rd_idx = 3'(i);
      #1;
      chk(rd_cfg == 9'h080, "R10", "reset config", int'(rd_cfg), 9'h080);
      chk(rd_level == m_lvl[i], "R10", "reset level", int'(rd_level), int'(m_lvl[i]));
      chk(ev_hit == 0, "R10", "reset events", int'(ev_hit), 0);
    end
    for (int s = 0; s < NS; s++)
      for (int mode = 0; mode < 2; mode++)
        for (int mk = 0; mk < 2; mk++)
          for (int d = 0; d < 16; d++) begin
            logic [8:0] w;
            w = 9'(9'h100 | (mk << 7) | (mode << 6) | 9'h030 | ((s + d) & 15));
            apply(0, s, w);
            apply(1, s, 9'(d));
            apply(2, s, 9'd1);
            apply(0, s, w ^ 9'h080);
            apply(3, s, 9'd0);
            apply(0, s, w);
            apply(2, s, 9'd0);
          end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule